// File: doc/BRIEF.md
# Cascadable Nibble Magnitude Comparator

This block compares two unsigned operands and raises exactly one of three flags: greater, less or equal. Its basic unit handles a four-bit slice and works from the top bit down: the first bit position where the operands differ decides the result. When every bit pair of a slice matches, the slice passes three cascade inputs straight to its flags. A comparison of a less significant slice can then decide a tie in a more significant one.

The top module chains a parameterised number of these slices. The cascade inputs of the top enter the least significant slice. The flags of each slice drive the cascade inputs of the slice above it, and the top's flags come from the most significant slice. With the default of two slices, the top is an eight-bit comparator. For an ordinary comparison, the cascade inputs are tied to greater=0, less=0, equal=1. A parameter selects one of two internal forms of the slice logic. Both forms give identical results.

The block is purely combinational. It has no clock and no state.

Top module: `mcmp_chain`

## Requirements
- R1: When the most significant differing bit position has a 1 in operand A, the flags are greater=1, less=0, equal=0.
- R2: When the most significant differing bit position has a 1 in operand B, the flags are greater=0, less=1, equal=0.
- R3: When A equals B, each flag equals its own cascade input. This holds for any combination of cascade inputs, including ones that are not one-hot.
- R4: With A=B=0 and the cascade inputs at greater=0, less=0, equal=1, only the equal flag is high.
- R5: Whenever exactly one cascade input is high, exactly one flag is high.
- R6: The equal flag is high exactly when every bit pair matches and the cascade equal input is high.
- R7: For the default of two slices, the flags match the unsigned relation between the full eight-bit operands. The least significant slice settles ties in the upper slice.
- R8: A difference in the upper slice decides the result, whatever the lower slice holds. Examples: A=0x80 against B=0x7F, and A=0x10 against B=0x0F.
- R9: When the operands differ, the cascade inputs have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | UNIT_W*UNITS (8) | Operand A, unsigned |
| b_i | input | UNIT_W*UNITS (8) | Operand B, unsigned |
| cas_gt_i | input | 1 | Cascade input: greater, from a less significant stage |
| cas_lt_i | input | 1 | Cascade input: less, from a less significant stage |
| cas_eq_i | input | 1 | Cascade input: equal, from a less significant stage |
| gt_o | output | 1 | A is greater than B |
| lt_o | output | 1 | A is less than B |
| eq_o | output | 1 | A equals B, qualified by cascade equal |

## Verification
All three flags are combinational, so each is due in the same cycle as the stimulus that produces it. The driver applies a new operand pair and cascade setting just after a rising clock edge. The monitor compares the flags at the following falling edge, half a period later, when the logic has long settled. The scoreboard queue holds at most one pending item, and each item is consumed at the first falling edge after it is pushed. The bench covers two configurations. A one-slice instance in the alternative logic form is checked over every operand pair and every cascade combination. The two-slice default is checked with random pairs and with the boundary pairs around the slice border.

// File: rtl/mcmp_pkg.sv
package mcmp_pkg;

   typedef struct packed {
      logic gt;
      logic lt;
      logic eq;
   } rel_t;

   localparam int STYLE_RIPPLE = 0;
   localparam int STYLE_PREFIX = 1;

endpackage

// File: rtl/mcmp_bit_rel.sv
module mcmp_bit_rel
   import mcmp_pkg::*;
(
   input  logic a_i,
   input  logic b_i,
   output rel_t rel_o
);

   always_comb begin
      rel_o.gt = a_i & ~b_i;
      rel_o.lt = ~a_i & b_i;
      rel_o.eq = ~(a_i ^ b_i);
   end

endmodule

// File: rtl/mcmp_unit.sv
module mcmp_unit
   import mcmp_pkg::*;
#(
   parameter int W     = 4,
   parameter int STYLE = STYLE_RIPPLE
)(
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  rel_t         cas_i,
   output rel_t         res_o
);

   logic [W-1:0] bit_gt;
   logic [W-1:0] bit_lt;
   logic [W-1:0] bit_eq;

   for (genvar i = 0; i < W; i++) begin : g_bit
      rel_t r;
      mcmp_bit_rel u_rel (
         .a_i   (a_i[i]),
         .b_i   (b_i[i]),
         .rel_o (r)
      );
      assign bit_gt[i] = r.gt;
      assign bit_lt[i] = r.lt;
      assign bit_eq[i] = r.eq;
   end

   if (STYLE == STYLE_RIPPLE) begin : g_ripple
      // Walk upward from bit 0; a higher differing bit overwrites a lower one.
      always_comb begin
         res_o = cas_i;
         for (int i = 0; i < W; i++) begin
            if (!bit_eq[i]) begin
               res_o.gt = bit_gt[i];
               res_o.lt = bit_lt[i];
               res_o.eq = 1'b0;
            end
         end
      end
   end else begin : g_prefix
      // eq_hi[i]: all bits at position i and above match.
      logic [W:0]   eq_hi;
      logic [W-1:0] gt_term;
      logic [W-1:0] lt_term;
      assign eq_hi[W] = 1'b1;
      for (genvar i = W-1; i >= 0; i--) begin : g_term
         assign eq_hi[i]   = eq_hi[i+1] & bit_eq[i];
         assign gt_term[i] = bit_gt[i] & eq_hi[i+1];
         assign lt_term[i] = bit_lt[i] & eq_hi[i+1];
      end
      always_comb begin
         res_o.gt = (|gt_term) | (eq_hi[0] & cas_i.gt);
         res_o.lt = (|lt_term) | (eq_hi[0] & cas_i.lt);
         res_o.eq = eq_hi[0] & cas_i.eq;
      end
   end

endmodule

// File: rtl/mcmp_chain.sv
module mcmp_chain
   import mcmp_pkg::*;
#(
   parameter int UNIT_W = 4,
   parameter int UNITS  = 2,
   parameter int STYLE  = STYLE_RIPPLE,
   localparam int W     = UNIT_W * UNITS
)(
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cas_gt_i,
   input  logic         cas_lt_i,
   input  logic         cas_eq_i,
   output logic         gt_o,
   output logic         lt_o,
   output logic         eq_o
);

   if (UNIT_W < 1 || UNITS < 1) begin : g_bad_size
      $error("mcmp_chain: UNIT_W and UNITS must be at least 1");
   end
   if (STYLE != STYLE_RIPPLE && STYLE != STYLE_PREFIX) begin : g_bad_style
      $error("mcmp_chain: unknown STYLE");
   end

   rel_t link [UNITS+1];

   assign link[0] = '{gt: cas_gt_i, lt: cas_lt_i, eq: cas_eq_i};

   // Slice k covers bits [k*UNIT_W +: UNIT_W]; slice 0 is least significant.
   for (genvar k = 0; k < UNITS; k++) begin : g_slice
      mcmp_unit #(
         .W     (UNIT_W),
         .STYLE (STYLE)
      ) u_unit (
         .a_i   (a_i[k*UNIT_W +: UNIT_W]),
         .b_i   (b_i[k*UNIT_W +: UNIT_W]),
         .cas_i (link[k]),
         .res_o (link[k+1])
      );
   end

   assign gt_o = link[UNITS].gt;
   assign lt_o = link[UNITS].lt;
   assign eq_o = link[UNITS].eq;

endmodule

// File: rtl/mcmp_chain_chk.sv
module mcmp_chain_chk #(
   parameter int W = 8
)(
   input logic [W-1:0] a_i,
   input logic [W-1:0] b_i,
   input logic         cas_gt_i,
   input logic         cas_lt_i,
   input logic         cas_eq_i,
   input logic         gt_o,
   input logic         lt_o,
   input logic         eq_o
);

   always_comb begin
      if ($onehot({cas_gt_i, cas_lt_i, cas_eq_i}))
         assert_onehot_out_R5: assert ($onehot({gt_o, lt_o, eq_o}));
      assert_eq_flag_R6: assert (eq_o == ((a_i == b_i) && cas_eq_i));
      if (a_i == b_i)
         assert_tie_copy_R3: assert ({gt_o, lt_o, eq_o} == {cas_gt_i, cas_lt_i, cas_eq_i});
      if (a_i > b_i)
         assert_greater_R1: assert (gt_o && !lt_o && !eq_o);
      if (a_i < b_i)
         assert_less_R2: assert (!gt_o && lt_o && !eq_o);
   end

endmodule

bind mcmp_chain mcmp_chain_chk #(.W(W)) u_chk (
   .a_i      (a_i),
   .b_i      (b_i),
   .cas_gt_i (cas_gt_i),
   .cas_lt_i (cas_lt_i),
   .cas_eq_i (cas_eq_i),
   .gt_o     (gt_o),
   .lt_o     (lt_o),
   .eq_o     (eq_o)
);

// File: tb/mcmp_chain_tb_top.sv
`timescale 1ns/1ps
module mcmp_chain_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   // Eight-bit default instance
   logic [7:0] a8, b8;
   logic [2:0] cas8;
   logic       gt8, lt8, eq8;

   // Single four-bit slice, alternative logic form
   logic [3:0] a4, b4;
   logic [2:0] cas4;
   logic       gt4, lt4, eq4;

   mcmp_chain dut_i (
      .a_i(a8), .b_i(b8),
      .cas_gt_i(cas8[2]), .cas_lt_i(cas8[1]), .cas_eq_i(cas8[0]),
      .gt_o(gt8), .lt_o(lt8), .eq_o(eq8)
   );

   mcmp_chain #(.UNIT_W(4), .UNITS(1), .STYLE(mcmp_pkg::STYLE_PREFIX)) dut4_i (
      .a_i(a4), .b_i(b4),
      .cas_gt_i(cas4[2]), .cas_lt_i(cas4[1]), .cas_eq_i(cas4[0]),
      .gt_o(gt4), .lt_o(lt4), .eq_o(eq4)
   );

   typedef struct {
      bit         wide;
      logic [2:0] cas;
      logic [2:0] exp;
      string      tag;
   } item_t;

   item_t sb_q[$];
   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // Reference model: {gt,lt,eq}
   function automatic logic [2:0] model(logic [7:0] a, logic [7:0] b, logic [2:0] cas);
      if (a > b)      return 3'b100;
      else if (a < b) return 3'b010;
      else            return cas;
   endfunction

   task automatic drive(bit wide, logic [7:0] a, logic [7:0] b, logic [2:0] cas, string tag);
      item_t it;
      @(posedge clk);
      #1;
      if (wide) begin
         a8 = a; b8 = b; cas8 = cas;
      end else begin
         a4 = a[3:0]; b4 = b[3:0]; cas4 = cas;
      end
      it.wide = wide;
      it.cas  = cas;
      it.exp  = wide ? model(a, b, cas) : model({4'h0, a[3:0]}, {4'h0, b[3:0]}, cas);
      it.tag  = tag;
      sb_q.push_back(it);
   endtask

   // Monitor: flags are combinational, compared half a cycle after driving.
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            item_t it;
            logic [2:0] got;
            it  = sb_q.pop_front();
            got = it.wide ? {gt8, lt8, eq8} : {gt4, lt4, eq4};
            n_checks++;
            if (got !== it.exp) begin
               n_fail++;
               $display("FAIL %s: flags actual=%b expected=%b", it.tag, got, it.exp);
            end
            if ($onehot(it.cas)) begin
               n_checks++;
               if (!$onehot(got)) begin
                  n_fail++;
                  $display("FAIL R5: flags actual=%b expected one-hot", got);
               end
            end
         end
      end
   end

   function automatic string tag4(logic [3:0] a, logic [3:0] b, logic [2:0] cas);
      if (a == b)       return (cas == 3'b001) ? "R6" : "R3";
      if (cas != 3'b001) return "R9";
      return (a > b) ? "R1" : "R2";
   endfunction

   initial begin
      a8 = '0; b8 = '0; cas8 = 3'b001;
      a4 = '0; b4 = '0; cas4 = 3'b001;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R4: zero operands, stand-alone cascade setting
      drive(1'b1, 8'h00, 8'h00, 3'b001, "R4");
      drive(1'b0, 8'h00, 8'h00, 3'b001, "R4");

      // Exhaustive single slice over every cascade combination (R1 R2 R3 R6 R9)
      for (int c = 0; c < 8; c++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               drive(1'b0, 8'(a), 8'(b), 3'(c), tag4(4'(a), 4'(b), 3'(c)));

      // R8: upper slice dominates
      drive(1'b1, 8'h80, 8'h7F, 3'b001, "R8");
      drive(1'b1, 8'h10, 8'h0F, 3'b001, "R8");
      drive(1'b1, 8'h0F, 8'h10, 3'b001, "R8");
      drive(1'b1, 8'h7F, 8'h80, 3'b010, "R8");
      // R7: tie in upper slice settled by lower slice
      drive(1'b1, 8'h35, 8'h34, 3'b001, "R7");
      drive(1'b1, 8'h34, 8'h35, 3'b001, "R7");
      drive(1'b1, 8'hFF, 8'hFF, 3'b001, "R7");
      // R3 through two slices with a non-one-hot cascade
      drive(1'b1, 8'hA5, 8'hA5, 3'b110, "R3");
      drive(1'b1, 8'h5A, 8'h5A, 3'b000, "R3");

      // R7 R9: random eight-bit pairs, random cascade settings
      for (int n = 0; n < 600; n++) begin
         logic [7:0] ra, rb;
         logic [2:0] rc;
         ra = 8'($urandom);
         rb = (n % 5 == 0) ? ra : 8'($urandom);
         rc = (n % 2 == 0) ? 3'b001 : 3'($urandom);
         drive(1'b1, ra, rb, rc, (ra == rb) ? "R3" : ((rc == 3'b001) ? "R7" : "R9"));
      end

      repeat (3) @(posedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule